// File: doc/BRIEF.md
# Command-Addressed Serial Register Port

This block is a three-wire serial slave that gives a host controller access to a small bank of configuration and result registers. The host lowers chip select and clocks bits in on the data input. The port samples each bit on the selected active clock edge, with the most significant bit first. Every transaction opens with an 8-bit command byte. The command names one of eight register addresses and asks for a single write, a single read, the start of a continuous read, or the end of one. A single access is followed by the register's own number of bits, and the port then waits for the next command byte. A continuous read keeps sending the chosen register, word after word, until the host shifts a stop command into the first byte of a word.

The serial clock, data input and chip select are brought into the system clock domain through synchronisers. A polarity strap picks which serial clock edge is active. Configuration registers drive parallel outputs. A separate result input loads the read-only data register, and a ready flag in the status register tracks it. A run of 32 consecutive ones on the data input sets the port and every register back to the reset state, so a host that has lost its place in the protocol can recover.

Top module: `cmdSerialPort`

## Requirements
- R1: After reset the outputs are: configuration word 0x01B0, filter word 0x200010, offset-trim byte 0x20, offset 0x800000, gain 0x59AEE7, test word 0x000000. The status register reads 0x80 and the data register reads 0.
- R2: Command byte layout. Bits 2:0 select the address: 0 status (read) or command (write), 1 data, 2 configuration, 3 filter, 4 trim, 5 offset, 6 gain, 7 test. Bits 5:4 select the operation: 00 write, 01 single read, 10 continuous read, 11 stop.
- R3: After a write command, the next W bits, MSB first, replace the selected register, where W is 8 for trim, 16 for configuration and 24 for filter, offset, gain and test. The port then returns to waiting for a command.
- R4: After a read command, the MSB of the selected register is on the data output before the first active edge. The output advances one bit on each active edge, and only then.
- R5: In continuous read the register is sent again on every word. If the first 8 bits shifted in during a word form a stop command (bit 7 = 0, bits 5:4 = 11), the port returns to the command state at the end of that word.
- R6: 32 consecutive ones on the data input, clocked while selected, return every register and the protocol state to the reset values. 31 ones followed by a zero change nothing.
- R7: Configuration bit 8 sets the data word length: 1 gives 24 bits, 0 gives the upper 16 bits. A write to the data address takes the full word and discards it. Status bit 7 is 0 once a result has been loaded and goes back to 1 after the data word has been read completely.
- R8: Configuration bits 1:0 choose which of three offset/gain pairs is written and driven out. Value 3 selects the same pair as value 2.
- R9: While chip select is high the data output is not driven and the configuration outputs hold. Raising chip select in the middle of a transfer discards the partial bits and returns the port to the command state.
- R10: With the polarity strap at 1 the falling serial clock edge is active. With the strap at 0 the rising edge is active.
- R11: A command byte with bit 7 set is ignored, and the port keeps waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host |
| dinIn | input | 1 | Serial data into the port |
| csN | input | 1 | Active-low chip select |
| polSel | input | 1 | Active-edge strap: 1 falling, 0 rising |
| resultIn | input | 24 | Conversion result to store in the data register |
| resultLoad | input | 1 | One-cycle strobe that loads resultIn |
| sdoOut | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for sdoOut (tri-state control) |
| modeOut | output | 16 | Configuration register |
| filterOut | output | 24 | Filter register |
| dacOut | output | 8 | Offset-trim register |
| offsetOut | output | 24 | Offset of the selected pair |
| gainOut | output | 24 | Gain of the selected pair |
| testOut | output | 24 | Test register |

## Verification
The assertions check four things on every cycle. The output enable and the configuration outputs stay quiet while chip select is deasserted. The data output moves only after an active edge. Register updates, word loads and the long-ones reset never coincide. No configuration output changes without an active edge. The scenarios can show what depends on sequence: command decoding, word lengths, continuous reads and their stop, the 31-versus-32 ones boundary, the routing of offset/gain pairs, a write discarded at the data address, the status ready flag, and operation with either clock polarity.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int WORD_W   = 24;
  localparam int CMD_W    = 8;
  localparam int SEL_W    = 3;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int ONES_RUN = 32;
  localparam int ONES_W   = $clog2(ONES_RUN + 1);
  localparam int NCOPY    = 3;
  localparam int CH_W     = 2;
  localparam int WL_BIT   = 8;

  localparam logic [15:0]       MODE_RST = 16'h01B0;
  localparam logic [WORD_W-1:0] FILT_RST = 24'h200010;
  localparam logic [7:0]        DAC_RST  = 8'h20;
  localparam logic [WORD_W-1:0] OFFS_RST = 24'h800000;
  localparam logic [WORD_W-1:0] GAIN_RST = 24'h59AEE7;
  localparam logic [WORD_W-1:0] TEST_RST = '0;

  localparam logic [SEL_W-1:0] ADDR_STAT = 3'd0;
  localparam logic [SEL_W-1:0] ADDR_DATA = 3'd1;
  localparam logic [SEL_W-1:0] ADDR_MODE = 3'd2;
  localparam logic [SEL_W-1:0] ADDR_FILT = 3'd3;
  localparam logic [SEL_W-1:0] ADDR_DAC  = 3'd4;
  localparam logic [SEL_W-1:0] ADDR_OFFS = 3'd5;
  localparam logic [SEL_W-1:0] ADDR_GAIN = 3'd6;
  localparam logic [SEL_W-1:0] ADDR_TEST = 3'd7;

  typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ} phase_t;
  typedef enum logic [1:0] {OP_WRITE = 2'b00, OP_READ = 2'b01,
                            OP_CONT = 2'b10, OP_STOP = 2'b11} op_t;

  typedef struct packed {
    logic             shiftIn;
    logic             shiftOut;
    logic             loadOut;
    logic             writeReg;
    logic             dataRead;
    logic             softReset;
    logic [SEL_W-1:0] sel;
  } strobe_t;

  function automatic logic [CNT_W-1:0] wordLen(input logic [SEL_W-1:0] sel, input logic wl);
    case (sel)
      ADDR_STAT, ADDR_DAC: wordLen = CNT_W'(8);
      ADDR_DATA:           wordLen = wl ? CNT_W'(24) : CNT_W'(16);
      ADDR_MODE:           wordLen = CNT_W'(16);
      default:             wordLen = CNT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkIn,
  input  logic              dinIn,
  input  logic              csN,
  input  logic              polSel,
  input  logic [WORD_W-1:0] nextIn,
  input  logic              wlBit,
  output strobe_t           strb,
  output logic              dinBit,
  output logic              csIdle,
  output logic              activeEdge
);
  logic [2:0] sclkSync;
  logic [1:0] dinSync, csSync;
  phase_t phase;
  logic contMode, stopSeen;
  logic [SEL_W-1:0] selReg;
  logic [CNT_W-1:0] bitCnt, curLen;
  logic [ONES_W-1:0] onesCnt;
  logic [CMD_W-1:0] cmdByte;
  logic lastBit, cmdOk, onesHit, isStop, stopNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkSync <= '0;
      dinSync  <= '0;
      csSync   <= '1;
    end else begin
      sclkSync <= {sclkSync[1:0], sclkIn};
      dinSync  <= {dinSync[0], dinIn};
      csSync   <= {csSync[0], csN};
    end
  end

  assign dinBit     = dinSync[1];
  assign csIdle     = csSync[1];
  assign activeEdge = !csSync[1] &&
                      (polSel ? (sclkSync[2] && !sclkSync[1]) : (!sclkSync[2] && sclkSync[1]));

  assign curLen  = (phase == PH_CMD) ? CNT_W'(CMD_W) : wordLen(selReg, wlBit);
  assign lastBit = (bitCnt == curLen - CNT_W'(1));
  assign cmdByte = nextIn[CMD_W-1:0];
  assign cmdOk   = !cmdByte[7];
  assign isStop  = cmdOk && (cmdByte[5:4] == OP_STOP);
  assign onesHit = dinBit && (onesCnt == ONES_W'(ONES_RUN - 1));
  assign stopNow = stopSeen || ((bitCnt == CNT_W'(CMD_W - 1)) && isStop);

  always_comb begin
    strb     = '0;
    strb.sel = selReg;
    if (activeEdge) begin
      strb.shiftIn = 1'b1;
      if (onesHit) begin
        strb.softReset = 1'b1;
      end else begin
        case (phase)
          PH_CMD: if (lastBit && cmdOk &&
                      (cmdByte[5:4] == OP_READ || cmdByte[5:4] == OP_CONT)) begin
            strb.loadOut = 1'b1;
            strb.sel     = cmdByte[SEL_W-1:0];
          end
          PH_WRITE: strb.writeReg = lastBit;
          PH_READ: begin
            strb.shiftOut = 1'b1;
            if (lastBit) begin
              strb.dataRead = (selReg == ADDR_DATA);
              strb.loadOut  = contMode && !stopNow;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; contMode <= 1'b0; stopSeen <= 1'b0;
      selReg <= '0; bitCnt <= '0; onesCnt <= '0;
    end else if (csIdle) begin
      phase <= PH_CMD; contMode <= 1'b0; stopSeen <= 1'b0;
      bitCnt <= '0; onesCnt <= '0;
    end else if (activeEdge) begin
      if (onesHit) begin
        phase <= PH_CMD; contMode <= 1'b0; stopSeen <= 1'b0;
        selReg <= '0; bitCnt <= '0; onesCnt <= '0;
      end else begin
        onesCnt <= dinBit ? onesCnt + ONES_W'(1) : '0;
        bitCnt  <= lastBit ? '0 : bitCnt + CNT_W'(1);
        case (phase)
          PH_CMD: if (lastBit && cmdOk) begin
            selReg <= cmdByte[SEL_W-1:0];
            case (cmdByte[5:4])
              OP_WRITE: phase <= (cmdByte[SEL_W-1:0] == ADDR_STAT) ? PH_CMD : PH_WRITE;
              OP_READ:  phase <= PH_READ;
              OP_CONT:  begin phase <= PH_READ; contMode <= 1'b1; end
              default:  contMode <= 1'b0;
            endcase
          end
          PH_WRITE: if (lastBit) phase <= PH_CMD;
          PH_READ: begin
            if (bitCnt == CNT_W'(CMD_W - 1) && isStop) stopSeen <= 1'b1;
            if (lastBit) begin
              stopSeen <= 1'b0;
              if (!(contMode && !stopNow)) begin
                phase <= PH_CMD; contMode <= 1'b0;
              end
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/sport_dpath.sv
module sport_dpath
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic              dinBit,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              resultLoad,
  output logic [WORD_W-1:0] nextIn,
  output logic              wlBit,
  output logic              sdoOut,
  output logic [15:0]       modeOut,
  output logic [WORD_W-1:0] filterOut,
  output logic [7:0]        dacOut,
  output logic [WORD_W-1:0] offsetOut,
  output logic [WORD_W-1:0] gainOut,
  output logic [WORD_W-1:0] testOut
);
  logic [WORD_W-1:0] shiftInReg, shiftOutReg, dataReg, readVal, aligned;
  logic [WORD_W-1:0] offsetArr [NCOPY];
  logic [WORD_W-1:0] gainArr [NCOPY];
  logic [CH_W-1:0] chIdx;
  logic notReady;
  logic [CNT_W-1:0] len;

  assign nextIn = {shiftInReg[WORD_W-2:0], dinBit};
  assign wlBit  = modeOut[WL_BIT];
  assign chIdx  = (modeOut[CH_W-1:0] >= CH_W'(NCOPY)) ? CH_W'(NCOPY - 1) : modeOut[CH_W-1:0];
  assign offsetOut = offsetArr[chIdx];
  assign gainOut   = gainArr[chIdx];

  always_comb begin
    case (strb.sel)
      ADDR_STAT: readVal = {16'b0, notReady, 7'b0};
      ADDR_DATA: readVal = wlBit ? dataReg : {8'b0, dataReg[WORD_W-1:8]};
      ADDR_MODE: readVal = {8'b0, modeOut};
      ADDR_FILT: readVal = filterOut;
      ADDR_DAC:  readVal = {16'b0, dacOut};
      ADDR_OFFS: readVal = offsetOut;
      ADDR_GAIN: readVal = gainOut;
      default:   readVal = testOut;
    endcase
    len     = wordLen(strb.sel, wlBit);
    aligned = readVal << (CNT_W'(WORD_W) - len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftInReg <= '0; shiftOutReg <= '0;
      modeOut <= MODE_RST; filterOut <= FILT_RST; dacOut <= DAC_RST; testOut <= TEST_RST;
      dataReg <= '0; notReady <= 1'b1;
    end else if (strb.softReset) begin
      shiftInReg <= '0; shiftOutReg <= '0;
      modeOut <= MODE_RST; filterOut <= FILT_RST; dacOut <= DAC_RST; testOut <= TEST_RST;
      dataReg <= '0; notReady <= 1'b1;
    end else begin
      if (strb.shiftIn) shiftInReg <= nextIn;
      if (strb.loadOut)       shiftOutReg <= aligned;
      else if (strb.shiftOut) shiftOutReg <= shiftOutReg << 1;
      if (strb.writeReg) begin
        case (strb.sel)
          ADDR_MODE: modeOut   <= nextIn[15:0];
          ADDR_FILT: filterOut <= nextIn;
          ADDR_DAC:  dacOut    <= nextIn[7:0];
          ADDR_TEST: testOut   <= nextIn;
          default: ;
        endcase
      end
      if (resultLoad) begin
        dataReg  <= resultIn;
        notReady <= 1'b0;
      end else if (strb.dataRead) begin
        notReady <= 1'b1;
      end
    end
  end

  assign sdoOut = shiftOutReg[WORD_W-1];

  for (genvar g = 0; g < NCOPY; g++) begin : gPair
    logic [WORD_W-1:0] offQ, gainQ;
    logic hit;
    assign hit = strb.writeReg && (chIdx == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offQ <= OFFS_RST; gainQ <= GAIN_RST;
      end else if (strb.softReset) begin
        offQ <= OFFS_RST; gainQ <= GAIN_RST;
      end else begin
        if (hit && strb.sel == ADDR_OFFS) offQ  <= nextIn;
        if (hit && strb.sel == ADDR_GAIN) gainQ <= nextIn;
      end
    end
    assign offsetArr[g] = offQ;
    assign gainArr[g]   = gainQ;
  end
endmodule

// File: rtl/cmdSerialPort.sv
module cmdSerialPort
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkIn,
  input  logic              dinIn,
  input  logic              csN,
  input  logic              polSel,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              resultLoad,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic [15:0]       modeOut,
  output logic [WORD_W-1:0] filterOut,
  output logic [7:0]        dacOut,
  output logic [WORD_W-1:0] offsetOut,
  output logic [WORD_W-1:0] gainOut,
  output logic [WORD_W-1:0] testOut
);
  strobe_t strb;
  logic [WORD_W-1:0] nextIn;
  logic wlBit, dinBit, csIdle, activeEdge;

  sport_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclkIn), .dinIn(dinIn), .csN(csN),
    .polSel(polSel), .nextIn(nextIn), .wlBit(wlBit), .strb(strb),
    .dinBit(dinBit), .csIdle(csIdle), .activeEdge(activeEdge)
  );

  sport_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dinBit(dinBit),
    .resultIn(resultIn), .resultLoad(resultLoad), .nextIn(nextIn),
    .wlBit(wlBit), .sdoOut(sdoOut), .modeOut(modeOut), .filterOut(filterOut),
    .dacOut(dacOut), .offsetOut(offsetOut), .gainOut(gainOut), .testOut(testOut)
  );

  assign sdoOe = !csIdle;
endmodule

// File: rtl/cmdSerialPort_chk.sv
module cmdSerialPort_chk
  import sport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              sdoOe,
  input logic              sdoOut,
  input logic              activeEdge,
  input strobe_t           strb,
  input logic [15:0]       modeOut,
  input logic [WORD_W-1:0] filterOut,
  input logic [7:0]        dacOut,
  input logic [WORD_W-1:0] testOut
);
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoOe); // R9

  AST_CFG_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |=>
      ($stable(modeOut) && $stable(filterOut) && $stable(dacOut) && $stable(testOut))); // R9

  AST_DOUT_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(activeEdge) |-> $stable(sdoOut)); // R4

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadOut, strb.writeReg, strb.softReset})); // R3

  AST_CFG_CHANGE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(modeOut) || !$stable(dacOut) || !$stable(filterOut)) |-> $past(activeEdge)); // R6
endmodule

bind cmdSerialPort cmdSerialPort_chk u_chk (.*);

// File: tb/tb_cmdSerialPort.sv
module tb_cmdSerialPort;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclkIn = 1'b1, dinIn = 1'b0, csN = 1'b1, polSel = 1'b1;
  logic [23:0] resultIn = '0;
  logic resultLoad = 1'b0;
  logic sdoOut, sdoOe;
  logic [15:0] modeOut;
  logic [23:0] filterOut, offsetOut, gainOut, testOut;
  logic [7:0] dacOut;

  typedef struct { logic [23:0] v; string tag; } exp_t;
  exp_t expQ[$];
  logic [23:0] actQ[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmdSerialPort dut (.*);

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (actQ.size() > 0 && expQ.size() > 0) begin
      automatic exp_t e = expQ.pop_front();
      automatic logic [23:0] a = actQ.pop_front();
      chk(e.tag, a, e.v);
    end
  end

  task automatic bitIO(input logic b, output logic o);
    dinIn = b;
    repeat (4) @(negedge clk);
    o = sdoOut;
    sclkIn = ~polSel;
    repeat (4) @(negedge clk);
    sclkIn = polSel;
  endtask

  task automatic xfer(input logic [23:0] v, input int n, output logic [23:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic o;
      bitIO(v[i], o);
      r[i] = o;
    end
  endtask

  task automatic sel();   csN = 1'b0; repeat (6) @(negedge clk); endtask
  task automatic desel(); csN = 1'b1; repeat (6) @(negedge clk); endtask

  task automatic doWrite(input logic [2:0] a, input logic [23:0] v, input int n);
    logic [23:0] r;
    xfer({16'b0, 5'b00000, a}, 8, r);
    xfer(v, n, r);
  endtask

  task automatic doRead(input logic [2:0] a, input int n, input logic [23:0] exp, input string tag);
    logic [23:0] r;
    xfer({16'b0, 5'b00010, a}, 8, r);
    xfer('0, n, r);
    expQ.push_back('{exp, tag});
    actQ.push_back(r);
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] v, input int n);
    sel(); doWrite(a, v, n); desel();
  endtask

  task automatic rd(input logic [2:0] a, input int n, input logic [23:0] exp, input string tag);
    sel(); doRead(a, n, exp, tag); desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] r;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset values
    chk("R1 mode", {8'b0, modeOut}, 24'h01B0);
    chk("R1 filter", filterOut, 24'h200010);
    chk("R1 trim", {16'b0, dacOut}, 24'h20);
    chk("R1 offset", offsetOut, 24'h800000);
    chk("R1 gain", gainOut, 24'h59AEE7);
    chk("R1 test", testOut, 24'h0);
    chk("R9 oe idle", {23'b0, sdoOe}, 24'h0);
    rd(3'd0, 8, 24'h80, "R1 status");
    rd(3'd1, 24, 24'h0, "R1 data");
    // R2/R3/R4 write and read back
    wr(3'd4, 24'h3C, 8);
    chk("R3 trim write", {16'b0, dacOut}, 24'h3C);
    rd(3'd4, 8, 24'h3C, "R4 trim read");
    wr(3'd3, 24'hA5C3F1, 24);
    chk("R3 filter write", filterOut, 24'hA5C3F1);
    rd(3'd3, 24, 24'hA5C3F1, "R4 filter read");
    wr(3'd7, 24'h00C0DE, 24);
    chk("R2 test addr", testOut, 24'h00C0DE);
    // R7 result / ready flag / word length
    @(negedge clk); resultIn = 24'h123456; resultLoad = 1'b1;
    @(negedge clk); resultLoad = 1'b0;
    rd(3'd0, 8, 24'h00, "R7 ready low");
    rd(3'd1, 24, 24'h123456, "R7 data 24");
    rd(3'd0, 8, 24'h80, "R7 ready after read");
    wr(3'd2, 24'h00B0, 16);
    rd(3'd1, 16, 24'h1234, "R7 data 16");
    wr(3'd1, 24'hABCD, 16);
    rd(3'd1, 16, 24'h1234, "R7 data write discarded");
    rd(3'd2, 16, 24'h00B0, "R7 mode after discard");
    // R8 pair selection
    wr(3'd2, 24'h00B1, 16);
    wr(3'd5, 24'h111111, 24);
    wr(3'd6, 24'h222222, 24);
    chk("R8 offset ch1", offsetOut, 24'h111111);
    chk("R8 gain ch1", gainOut, 24'h222222);
    wr(3'd2, 24'h00B0, 16);
    chk("R8 offset ch0", offsetOut, 24'h800000);
    chk("R8 gain ch0", gainOut, 24'h59AEE7);
    wr(3'd2, 24'h00B3, 16);
    wr(3'd5, 24'h333333, 24);
    wr(3'd2, 24'h00B2, 16);
    chk("R8 ch3 aliases ch2", offsetOut, 24'h333333);
    // R5 continuous read with stop
    sel();
    xfer(24'h22, 8, r);
    xfer(24'h0, 16, r); expQ.push_back('{24'h00B2, "R5 word1"}); actQ.push_back(r);
    xfer(24'h0, 16, r); expQ.push_back('{24'h00B2, "R5 word2"}); actQ.push_back(r);
    xfer(24'h3000, 16, r); expQ.push_back('{24'h00B2, "R5 stop word"}); actQ.push_back(r);
    doRead(3'd4, 8, 24'h3C, "R5 command after stop");
    desel();
    // R11 invalid command ignored
    sel();
    xfer(24'h84, 8, r);
    doRead(3'd4, 8, 24'h3C, "R11 bad command skipped");
    desel();
    chk("R11 trim unchanged", {16'b0, dacOut}, 24'h3C);
    // R9 chip select abort
    sel(); xfer(24'h04, 8, r); xfer(24'hA, 4, r); desel();
    chk("R9 partial discarded", {16'b0, dacOut}, 24'h3C);
    chk("R9 oe off", {23'b0, sdoOe}, 24'h0);
    rd(3'd4, 8, 24'h3C, "R9 command state after abort");
    // R10 rising-edge polarity
    polSel = 1'b0; sclkIn = 1'b0; repeat (8) @(negedge clk);
    wr(3'd4, 24'h5A, 8);
    chk("R10 rising write", {16'b0, dacOut}, 24'h5A);
    rd(3'd4, 8, 24'h5A, "R10 rising read");
    polSel = 1'b1; sclkIn = 1'b1; repeat (8) @(negedge clk);
    // R6 long-ones reset boundary
    sel(); xfer(24'hFFFFFF, 24, r); xfer(24'hFE, 8, r); desel();
    chk("R6 31 ones no reset", {16'b0, dacOut}, 24'h5A);
    sel(); xfer(24'hFFFFFF, 24, r); xfer(24'hFF, 8, r); desel();
    chk("R6 trim reset", {16'b0, dacOut}, 24'h20);
    chk("R6 mode reset", {8'b0, modeOut}, 24'h01B0);
    chk("R6 filter reset", filterOut, 24'h200010);
    chk("R6 offset reset", offsetOut, 24'h800000);
    rd(3'd0, 8, 24'h80, "R6 status reset");
    rd(3'd1, 24, 24'h0, "R6 data reset");
    repeat (4) @(negedge clk);
    chk("scoreboard drained", 24'(expQ.size() + actQ.size()), 24'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule